// File: doc/BRIEF.md
# Interrupt Status and Mask Register Group

This block holds the interrupt state for ten interrupt sources behind a 32-bit word-access register bus. A status register collects pending events. Hardware pulses set status bits, and software sets them through a trigger register. Software clears them by writing ones to the status register.

A mask register decides which pending bits may reach the single level interrupt output. The mask cannot be written directly. Software clears mask bits through an enable register and sets them through a disable register. The enable, disable and trigger registers have no storage.

The output `irq` is high whenever a status bit is set while its mask bit is clear. It is computed from the registered status and mask, so it follows any write on the next clock.

Top module: `irq_reg_bank`

## Requirements
- R1: Register word offsets are status 0x00, mask 0x04, enable 0x08, disable 0x0C and trigger 0x10. Status and mask occupy bits [9:0], and bits [31:10] of every register, and all unmapped offsets, read as zero.
- R2: A write to status clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R3: The mask resets to 0x3FF, and a write to the mask offset leaves the mask unchanged.
- R4: A write to enable clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R5: A write to disable sets every mask bit written as 1 and leaves the other mask bits unchanged.
- R6: A write to trigger sets every status bit written as 1.
- R7: `irq` is 1 exactly when some status bit is 1 while the same mask bit is 0, and it reflects a write from the cycle after the write.
- R8: Reads of enable, disable and trigger return zero.
- R9: Each 1 on `hw_event` in a cycle sets the matching status bit. When the same bit is also cleared by a status write in that cycle, the bit ends up set.
- R10: A write with any byte strobe low, or with address bits [1:0] not zero, changes no state.
- R11: After reset the status register is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address within the group |
| bus_strb | input | 4 | Byte strobes; all four must be high for a write to be accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while a read is selected |
| hw_event | input | NUM_SRC (10) | Per-source event pulses that set status bits |
| irq | output | 1 | Level interrupt output |

## Verification
The hardest case to reach from the ports is a hardware event and a write-one-to-clear that hit the same status bit on the same clock edge. The bench raises `hw_event` in the same half-cycle in which it drives the clearing write, so both land on one edge. It then reads the status back to confirm that the set won. Partial-strobe and misaligned writes are aimed at the trigger register with all source bits set, so any wrongly accepted write would show in the status.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int BUS_W      = 32;
    localparam int STRB_W     = BUS_W / 8;

    // word indexes (byte offset / 4)
    localparam int WIDX_STATUS  = 0;
    localparam int WIDX_MASK    = 1;
    localparam int WIDX_ENABLE  = 2;
    localparam int WIDX_DISABLE = 3;
    localparam int WIDX_TRIGGER = 4;

    typedef struct packed {
        logic wr_status;
        logic wr_enable;
        logic wr_disable;
        logic wr_trigger;
        logic rd_status;
        logic rd_mask;
        logic rd_wonly;
    } dec_t;

    function automatic logic full_word(input logic [STRB_W-1:0] strb);
        return &strb;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STRB_W-1:0] bus_strb,
    output dec_t              dec
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;
    logic             wr_ok;
    logic             rd_ok;

    assign word  = bus_addr[ADDR_W-1:2];
    assign wr_ok = bus_sel && bus_wr && full_word(bus_strb) && (bus_addr[1:0] == 2'b00);
    assign rd_ok = bus_sel && !bus_wr;

    always_comb begin
        dec            = '0;
        dec.wr_status  = wr_ok && (word == IDX_W'(WIDX_STATUS));
        dec.wr_enable  = wr_ok && (word == IDX_W'(WIDX_ENABLE));
        dec.wr_disable = wr_ok && (word == IDX_W'(WIDX_DISABLE));
        dec.wr_trigger = wr_ok && (word == IDX_W'(WIDX_TRIGGER));
        dec.rd_status  = rd_ok && (word == IDX_W'(WIDX_STATUS));
        dec.rd_mask    = rd_ok && (word == IDX_W'(WIDX_MASK));
        dec.rd_wonly   = rd_ok && ((word == IDX_W'(WIDX_ENABLE)) ||
                                   (word == IDX_W'(WIDX_DISABLE)) ||
                                   (word == IDX_W'(WIDX_TRIGGER)));
    end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_SRC = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] clr_v,
    input  logic [NUM_SRC-1:0] set_v,
    output logic [NUM_SRC-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_v) | set_v;
        end
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|(clr_v & ~set_v)) |=> ((status & $past(clr_v & ~set_v)) == '0)); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((status & $past(set_v)) == $past(set_v))); // R9

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_SRC = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] en_v,
    input  logic [NUM_SRC-1:0] dis_v,
    output logic [NUM_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
        end else begin
            mask <= (mask & ~en_v) | dis_v;
        end
    end

    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|en_v) |=> ((mask & $past(en_v)) == '0)); // R4

    AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|dis_v) |=> ((mask & $past(dis_v)) == $past(dis_v))); // R5

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!(|en_v) && !(|dis_v)) |=> $stable(mask)); // R3

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_regs_pkg::*;
#(
    parameter int NUM_SRC = 10,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [STRB_W-1:0]  bus_strb,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] hw_event,
    output logic               irq
);
    dec_t               dec;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] clr_v, set_v, en_v, dis_v;
    logic [NUM_SRC-1:0] status, mask;
    logic               unused_wdata_hi;

    assign wbits           = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_SRC];

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_strb (bus_strb),
        .dec      (dec)
    );

    assign clr_v = dec.wr_status  ? wbits : '0;
    assign set_v = (dec.wr_trigger ? wbits : '0) | hw_event;
    assign en_v  = dec.wr_enable  ? wbits : '0;
    assign dis_v = dec.wr_disable ? wbits : '0;

    irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk    (clk),
        .rst    (rst),
        .clr_v  (clr_v),
        .set_v  (set_v),
        .status (status)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .en_v  (en_v),
        .dis_v (dis_v),
        .mask  (mask)
    );

    always_comb begin
        bus_rdata = '0;
        if (dec.rd_status) begin
            bus_rdata[NUM_SRC-1:0] = status;
        end else if (dec.rd_mask) begin
            bus_rdata[NUM_SRC-1:0] = mask;
        end
    end

    assign irq = |(status & ~mask);

    AST_WONLY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        dec.rd_wonly |-> (bus_rdata == '0)); // R8

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq); // R7

endmodule

// File: tb/irq_reg_bank_tb.sv
module irq_reg_bank_tb;
    localparam int N  = 10;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_STAT = 8'h00, A_MASK = 8'h04, A_EN = 8'h08,
                              A_DIS = 8'h0C, A_TRIG = 8'h10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_strb = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  hw_event = '0;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_reg_bank #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hw_event(hw_event), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // write, optionally with an event pulse in the same cycle
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [3:0] s = 4'hF, input logic [N-1:0] ev = '0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
        hw_event = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_strb = '0; hw_event = '0;
    endtask

    task automatic pulse(input logic [N-1:0] ev);
        @(negedge clk);
        hw_event = ev;
        @(negedge clk);
        hw_event = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STAT, d); check("R11 status after reset", d, 32'h0);
        rd(A_MASK, d); check("R3 mask after reset", d, 32'h3FF);
        check("R11 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        wr(A_TRIG, 32'h005);
        rd(A_STAT, d); check("R6 trigger sets status", d, 32'h005);
        check("R7 irq low while masked", {31'b0, irq}, 32'h0);
        rd(A_TRIG, d); check("R8 trigger reads zero", d, 32'h0);
    endtask

    task automatic t_enable_disable();
        logic [31:0] d;
        wr(A_EN, 32'h001);
        rd(A_MASK, d); check("R4 enable clears mask bit", d, 32'h3FE);
        check("R7 irq high when unmasked", {31'b0, irq}, 32'h1);
        wr(A_DIS, 32'h001);
        rd(A_MASK, d); check("R5 disable sets mask bit", d, 32'h3FF);
        check("R7 irq low after disable", {31'b0, irq}, 32'h0);
        wr(A_EN, 32'h004);
        rd(A_MASK, d); check("R4 enable second bit", d, 32'h3FB);
        check("R7 irq from bit2", {31'b0, irq}, 32'h1);
        rd(A_EN, d); check("R8 enable reads zero", d, 32'h0);
        rd(A_DIS, d); check("R8 disable reads zero", d, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(A_STAT, 32'h004);
        rd(A_STAT, d); check("R2 write one clears", d, 32'h001);
        check("R7 irq low after clear", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'h000);
        rd(A_STAT, d); check("R2 write zero keeps", d, 32'h001);
    endtask

    task automatic t_mask_ro();
        logic [31:0] d;
        wr(A_MASK, 32'h000);
        rd(A_MASK, d); check("R3 mask write ignored", d, 32'h3FB);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(A_TRIG, 32'hFFFF_FC00);
        rd(A_STAT, d); check("R1 reserved trigger bits", d, 32'h001);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_MASK, d); check("R1 mask upper bits zero", d, 32'h000);
        wr(A_DIS, 32'h3FF);
        rd(8'h20, d); check("R1 unmapped reads zero", d, 32'h0);
    endtask

    task automatic t_hw_event();
        logic [31:0] d;
        pulse(10'h200);
        rd(A_STAT, d); check("R9 event sets status", d, 32'h201);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(A_STAT, 32'h200, 4'hF, 10'h200);
        rd(A_STAT, d); check("R9 set wins over clear", d, 32'h201);
        wr(A_STAT, 32'h3FF);
        rd(A_STAT, d); check("R2 clear all", d, 32'h0);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        wr(A_TRIG, 32'h3FF, 4'h3);
        rd(A_STAT, d); check("R10 partial strobe ignored", d, 32'h0);
        wr(A_TRIG | 8'h1, 32'h3FF);
        rd(A_STAT, d); check("R10 misaligned ignored", d, 32'h0);
        wr(A_EN, 32'h3FF, 4'hE);
        rd(A_MASK, d); check("R10 partial enable ignored", d, 32'h3FF);
    endtask

    task automatic t_irq_event();
        wr(A_EN, 32'h010);
        check("R7 irq low without status", {31'b0, irq}, 32'h0);
        pulse(10'h010);
        check("R7 irq after unmasked event", {31'b0, irq}, 32'h1);
        pulse(10'h020);
        wr(A_STAT, 32'h010);
        check("R7 irq low with only masked bit", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        t_reset();
        t_trigger();
        t_enable_disable();
        t_w1c();
        t_mask_ro();
        t_reserved();
        t_hw_event();
        t_collision();
        t_partial();
        t_irq_event();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule